// File: doc/BRIEF.md
# Diagnostic RAM Test Access Port

This block owns the 33-bit-wide packet buffer that three packet FIFOs share, and adds a diagnostic window through which a host bus can fill and read back that buffer directly. While the test mode is on, every host access to one fixed window address reaches the next buffer location in turn. An internal pointer, which the host can reset to zero, supplies the location. The FIFO status logic outside the block is told to hold still for as long as the mode lasts.

Each buffer word holds a 32-bit data quadlet and a marker bit that flags the first quadlet of a packet. On a window write the marker comes from a bit in the diagnostics register. On a window read the quadlet goes back to the host, and the stored marker is compared with that same register bit. A disagreement latches a sticky error flag and stalls nothing. Test software uses the block to run pattern tests over the whole buffer, including the marker column.

Top module: `diag_ram_test_port`

## Requirements
- R1: After reset the diagnostics register reads 0, `host_rdata` is 0 and `fifo_freeze` is low.
- R2: Test mode is active, and `fifo_freeze` is high, exactly while the enable bit (bit 0) and the test bit (bit 1) of the diagnostics register are both 1.
- R3: Writing the diagnostics register with bit 2 (pointer clear) set resets the buffer pointer to 0. Bit 2 always reads back as 0.
- R4: In test mode, the nth read or write at address 0x80 after a pointer clear reaches location n-1. The pointer steps by one after every such access and wraps from 511 to 0.
- R5: A test-mode write at 0x80 stores `host_wdata` in bits 31:0 of the word and diagnostics bit 3 (marker) in bit 32.
- R6: A test-mode read at 0x80 returns bits 31:0 of the addressed word on `host_rdata` one clock after the read strobe.
- R7: A test-mode read whose stored bit 32 differs from diagnostics bit 3 sets the error flag (diagnostics bit 4). The flag stays set through later matching reads.
- R8: The error flag is cleared by a pointer clear or by any test-mode write at 0x80. Host writes to bit 4 are ignored.
- R9: With test mode inactive, accesses at 0x80 change neither the buffer nor the pointer, and a read there returns 0.
- R10: The diagnostics register is read at address 0x40, one clock after the strobe, as {err, marker, 0, test, enable} in bits 4:0, with zeros above. Reads at any address other than 0x40 and 0x80 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Host bus address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| fifo_freeze | output | 1 | High while test mode holds the FIFO status still |

## Verification
The assertions assume the host never raises `host_wr` and `host_rd` in the same cycle, and that each strobe marks exactly one access, so one step of the pointer matches one strobe cycle. The bench drives every access from a task that raises a single strobe for one cycle and lowers it before the next access. It drives the inputs at the falling edge, so the properties always see settled strobe, address and data values. Diagnostics register writes and window accesses never share a cycle, which keeps the ordering between pointer clear, stepping and flag updates unambiguous.

// File: rtl/diag_ram_pkg.sv
package diag_ram_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned DEPTH     = 512;
    localparam int unsigned HADDR_W   = 8;
    localparam logic [7:0]  WIN_ADDR  = 8'h80;
    localparam logic [7:0]  DIAG_ADDR = 8'h40;

    // diagnostics register layout
    localparam int unsigned DIAG_W = 5;
    localparam int unsigned B_EN   = 0;
    localparam int unsigned B_TEST = 1;
    localparam int unsigned B_CLR  = 2;
    localparam int unsigned B_MARK = 3;
    localparam int unsigned B_ERR  = 4;

    typedef struct packed {
        logic en;
        logic test;
        logic mark;
        logic err;
    } diag_t;

endpackage

// File: rtl/diag_ctrl_reg.sv
module diag_ctrl_reg
    import diag_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DIAG_W-1:0] cfg_bits,
    input  logic              win_wr,
    input  logic              win_rd,
    input  logic              stored_mark,
    output diag_t             diag_q,
    output logic              ptr_clr
);

    diag_t diag_d;

    always_comb begin
        diag_d  = diag_q;
        ptr_clr = cfg_we & cfg_bits[B_CLR];
        if (cfg_we) begin
            diag_d.en   = cfg_bits[B_EN];
            diag_d.test = cfg_bits[B_TEST];
            diag_d.mark = cfg_bits[B_MARK];
            if (cfg_bits[B_CLR]) begin
                diag_d.err = 1'b0;
            end
        end
        if (win_wr) begin
            diag_d.err = 1'b0;
        end
        if (win_rd && (stored_mark != diag_q.mark)) begin
            diag_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diag_q <= '0;
        end else begin
            diag_q <= diag_d;
        end
    end

endmodule

// File: rtl/diag_addr_ctr.sv
module diag_addr_ctr #(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr_q
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (clear) begin
            addr_d = '0;
        end else if (step) begin
            addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/diag_ram.sv
module diag_ram #(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned WORD_W = 33,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rword
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wword;
        end
    end

    assign rword = mem_q[addr];

endmodule

// File: rtl/diag_ram_test_port.sv
module diag_ram_test_port
    import diag_ram_pkg::*;
#(
    parameter int unsigned P_DATA_W   = DATA_W,
    parameter int unsigned P_DEPTH    = DEPTH,
    parameter int unsigned P_HADDR_W  = HADDR_W,
    parameter logic [P_HADDR_W-1:0] P_WIN_ADDR  = P_HADDR_W'(WIN_ADDR),
    parameter logic [P_HADDR_W-1:0] P_DIAG_ADDR = P_HADDR_W'(DIAG_ADDR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P_HADDR_W-1:0] host_addr,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [P_DATA_W-1:0]  host_wdata,
    output logic [P_DATA_W-1:0]  host_rdata,
    output logic                 fifo_freeze
);

    localparam int unsigned WORD_W = P_DATA_W + 1;
    localparam int unsigned AW     = $clog2(P_DEPTH);

    typedef struct packed {
        logic [P_DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    diag_t             diag_q;
    logic              ptr_clr;
    logic              test_act;
    logic              hit_win;
    logic              hit_diag;
    logic              win_wr;
    logic              win_rd;
    logic              cfg_we;
    logic [AW-1:0]     ctr_addr;
    logic [WORD_W-1:0] ram_word;
    logic [WORD_W-1:0] ram_wword;
    logic              err_flag;
    logic              mark_flag;
    logic [P_DATA_W-1:0] diag_image;

    assign test_act  = diag_q.en & diag_q.test;
    assign hit_win   = (host_addr == P_WIN_ADDR);
    assign hit_diag  = (host_addr == P_DIAG_ADDR);
    assign win_wr    = test_act & hit_win & host_wr;
    assign win_rd    = test_act & hit_win & host_rd;
    assign cfg_we    = hit_diag & host_wr;
    assign ram_wword = {diag_q.mark, host_wdata};
    assign err_flag  = diag_q.err;
    assign mark_flag = diag_q.mark;

    always_comb begin
        diag_image         = '0;
        diag_image[B_EN]   = diag_q.en;
        diag_image[B_TEST] = diag_q.test;
        diag_image[B_MARK] = diag_q.mark;
        diag_image[B_ERR]  = diag_q.err;
    end

    diag_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_bits    (host_wdata[DIAG_W-1:0]),
        .win_wr      (win_wr),
        .win_rd      (win_rd),
        .stored_mark (ram_word[WORD_W-1]),
        .diag_q      (diag_q),
        .ptr_clr     (ptr_clr)
    );

    diag_addr_ctr #(
        .DEPTH (P_DEPTH)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ptr_clr),
        .step   (win_wr | win_rd),
        .addr_q (ctr_addr)
    );

    diag_ram #(
        .DEPTH  (P_DEPTH),
        .WORD_W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (win_wr),
        .addr  (ctr_addr),
        .wword (ram_wword),
        .rword (ram_word)
    );

    always_comb begin
        st_d.rdata = '0;
        if (host_rd) begin
            if (hit_diag) begin
                st_d.rdata = diag_image;
            end else if (win_rd) begin
                st_d.rdata = ram_word[P_DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata  = st_q.rdata;
    assign fifo_freeze = test_act;

endmodule

// File: rtl/diag_ram_test_port_chk.sv
module diag_ram_test_port_chk #(
    parameter int unsigned P_DATA_W  = 32,
    parameter int unsigned P_HADDR_W = 8,
    parameter int unsigned AW        = 9,
    parameter int unsigned P_DEPTH   = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [P_HADDR_W-1:0] host_addr,
    input logic                 host_wr,
    input logic                 host_rd,
    input logic [P_DATA_W-1:0]  host_wdata,
    input logic [P_DATA_W-1:0]  host_rdata,
    input logic                 fifo_freeze,
    input logic [AW-1:0]        ctr_addr,
    input logic                 err_flag,
    input logic                 mark_flag,
    input logic                 stored_mark
);

    localparam logic [P_HADDR_W-1:0] WIN  = P_HADDR_W'(8'h80);
    localparam logic [P_HADDR_W-1:0] DIAG = P_HADDR_W'(8'h40);
    localparam logic [AW-1:0]        LAST = AW'(P_DEPTH - 1);

    logic acc_win;
    assign acc_win = (host_addr == WIN) && (host_wr || host_rd);

    p_freeze_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == DIAG && host_wdata[1:0] == 2'b11) |=> fifo_freeze);

    p_freeze_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == DIAG && host_wdata[1:0] != 2'b11) |=> !fifo_freeze);

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == DIAG && host_wdata[2]) |=> (ctr_addr == '0));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_freeze && acc_win) |=>
            (ctr_addr == (($past(ctr_addr) == LAST) ? '0 : AW'($past(ctr_addr) + 1'b1))));

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_freeze && host_rd && host_addr == WIN && stored_mark != mark_flag) |=> err_flag);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_freeze && host_wr && host_addr == WIN) |=> !err_flag);

    p_idle_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_freeze && acc_win) |=> $stable(ctr_addr));

    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_freeze && host_rd && host_addr == WIN) |=> (host_rdata == '0));

endmodule

bind diag_ram_test_port diag_ram_test_port_chk #(
    .P_DATA_W  (P_DATA_W),
    .P_HADDR_W (P_HADDR_W),
    .AW        (AW),
    .P_DEPTH   (P_DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .fifo_freeze (fifo_freeze),
    .ctr_addr    (ctr_addr),
    .err_flag    (err_flag),
    .mark_flag   (mark_flag),
    .stored_mark (ram_word[WORD_W-1])
);

// File: tb/diag_ram_test_port_tb.sv
module diag_ram_test_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        fifo_freeze;

    int n_checks = 0;
    int n_err = 0;

    localparam logic [7:0] WIN  = 8'h80;
    localparam logic [7:0] DIAG = 8'h40;

    always #4 clk = ~clk;

    diag_ram_test_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .fifo_freeze (fifo_freeze)
    );

    // op: 0 window write, 1 window read, 2 pointer clear
    typedef struct packed {
        logic [1:0]  op;
        logic        mark;
        logic [31:0] data;
        logic        exp_err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 1'b0, 32'h0000_0000, 1'b0},
        '{2'd0, 1'b1, 32'hA5A5_0001, 1'b0},
        '{2'd0, 1'b0, 32'h5A5A_0002, 1'b0},
        '{2'd0, 1'b1, 32'hDEAD_0003, 1'b0},
        '{2'd2, 1'b1, 32'h0000_0000, 1'b0},
        '{2'd1, 1'b1, 32'hA5A5_0001, 1'b0},
        '{2'd1, 1'b1, 32'h5A5A_0002, 1'b1},
        '{2'd1, 1'b1, 32'hDEAD_0003, 1'b1},
        '{2'd2, 1'b0, 32'h0000_0000, 1'b0},
        '{2'd1, 1'b0, 32'hA5A5_0001, 1'b1},
        '{2'd2, 1'b1, 32'h0000_0000, 1'b0},
        '{2'd1, 1'b1, 32'hA5A5_0001, 1'b0},
        '{2'd1, 1'b1, 32'h5A5A_0002, 1'b1},
        '{2'd0, 1'b0, 32'h0BAD_F00D, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        d = host_rdata;
        host_rd = 1'b0;
    endtask

    // diag bits: 0 enable, 1 test, 2 clear, 3 marker
    function automatic logic [31:0] dcfg(input logic en, input logic tst,
                                         input logic clr, input logic mk);
        return {28'd0, mk, clr, tst, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdata after reset", host_rdata, 32'h0);
        chk("R1 freeze after reset", {31'd0, fifo_freeze}, 32'h0);
        rst_n = 1'b1;
        hread(DIAG, rd);
        chk("R1 diag after reset", rd, 32'h0);

        // R2 enable alone is not test mode
        hwrite(DIAG, dcfg(1, 0, 0, 0));
        chk("R2 enable only", {31'd0, fifo_freeze}, 32'h0);
        hwrite(DIAG, dcfg(0, 1, 0, 0));
        chk("R2 test only", {31'd0, fifo_freeze}, 32'h0);
        hwrite(DIAG, dcfg(1, 1, 0, 0));
        chk("R2 both set", {31'd0, fifo_freeze}, 32'h1);

        // table walk: R5 R6 R7 R8 R3
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].op == 2'd2) begin
                hwrite(DIAG, dcfg(1, 1, 1, TBL[i].mark));
            end else begin
                hwrite(DIAG, dcfg(1, 1, 0, TBL[i].mark));
                if (TBL[i].op == 2'd0) begin
                    hwrite(WIN, TBL[i].data);
                end else begin
                    hread(WIN, rd);
                    chk("R5/R6 table read data", rd, TBL[i].data);
                end
            end
            hread(DIAG, rd);
            chk("R7/R8 table err flag", {31'd0, rd[4]}, {31'd0, TBL[i].exp_err});
        end

        // R8 host cannot set err; R10 readback layout; R3 clear reads 0
        hwrite(DIAG, 32'h0000_001F);
        hread(DIAG, rd);
        chk("R10 R3 R8 diag readback", rd, 32'h0000_000B);

        // R10 other address reads zero
        hread(8'h10, rd);
        chk("R10 other address", rd, 32'h0);

        // R9 inactive mode: no effect on RAM or pointer
        hwrite(DIAG, dcfg(1, 1, 1, 0));
        hwrite(WIN, 32'h1111_0000);
        hwrite(DIAG, dcfg(1, 0, 0, 0));
        chk("R2 freeze drops", {31'd0, fifo_freeze}, 32'h0);
        hwrite(WIN, 32'h2222_0000);
        hread(WIN, rd);
        chk("R9 inactive read zero", rd, 32'h0);
        hwrite(DIAG, dcfg(1, 1, 0, 0));
        hwrite(WIN, 32'h3333_0000);
        hwrite(DIAG, dcfg(1, 1, 1, 0));
        hread(WIN, rd);
        chk("R9 loc0 untouched", rd, 32'h1111_0000);
        hread(WIN, rd);
        chk("R9 pointer not stepped", rd, 32'h3333_0000);

        // R4 wrap: 513 writes, the last lands on location 0
        hwrite(DIAG, dcfg(1, 1, 1, 0));
        for (int k = 0; k < 513; k++) begin
            hwrite(WIN, 32'hC000_0000 + k);
        end
        hwrite(DIAG, dcfg(1, 1, 1, 0));
        hread(WIN, rd);
        chk("R4 wrap to loc0", rd, 32'hC000_0200);
        hread(WIN, rd);
        chk("R4 loc1 after wrap", rd, 32'hC000_0001);
        for (int k = 2; k < 511; k++) begin
            hread(WIN, rd);
        end
        hread(WIN, rd);
        chk("R4 loc511", rd, 32'hC000_01FF);
        hread(WIN, rd);
        chk("R4 read wraps to loc0", rd, 32'hC000_0200);

        // R5 marker stored: read with marker 1 must flag
        hwrite(DIAG, dcfg(1, 1, 1, 1));
        hread(WIN, rd);
        hread(DIAG, rd);
        chk("R5 marker bit stored as 0", {31'd0, rd[4]}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule